// File: doc/BRIEF.md
# Clamp On-Time Overpower Fault Timer

This block guards a load-dump clamp against running too long. It samples a single-bit "clamp conducting" level on a slow tick, 100 µs by default, which a prescaler derives from the system clock. Each tick on which the clamp is conducting adds one to an accumulator. The ticks are grouped into back-to-back windows that are one second long by default, and the accumulator restarts from zero at the start of every window.

If the clamp's total on-time inside one window goes beyond the selected limit, the block latches a fault and raises a shutdown request at once. It does not wait for the window to end. A variant pin chooses the limit, either the low one or the high one, but its value is captured only while power-on reset is held. Once the fault is set, the accumulator and the window position stop moving, and only another power-on reset brings the block back to normal operation.

The on-time total is also driven onto an output so that other logic can observe it. By default the limits are 512 and 768 ticks (51.2 ms and 76.8 ms) and a window is 10000 ticks. All of these values, along with the clock rate, are parameters.

Top module: `ontime_guard`

## Requirements
- R1: While power-on reset is held and on the cycle after it is released, `faultFlag` and `shutdownReq` are 0 and `onCount` is 0.
- R2: The clamp input passes through two synchronizer flops. On every tick, if the synchronized level is 1, `onCount` rises by exactly one. Between ticks, or while the synchronized level is 0, `onCount` does not change.
- R3: A window is WINDOW_TICKS ticks long. On the last tick of each window that ends without a fault, `onCount` returns to 0, and any sample taken on that tick is dropped.
- R4: With the low variant (`variantHigh` = 0 at reset), the fault sets on the tick that would carry `onCount` to LOW_TICKS+1. If a window holds exactly LOW_TICKS on-ticks, no fault occurs.
- R5: With the high variant (`variantHigh` = 1 at reset), the fault sets on the tick that would carry `onCount` to HIGH_TICKS+1. In that case `onCount` reads HIGH_TICKS+1 once the fault is set.
- R6: The fault is declared on the same tick edge on which the limit is passed, even in the middle of a window. On that edge `onCount` also takes its increment, so it reads limit+1.
- R7: After the fault sets, `faultFlag` and `shutdownReq` both stay at 1 whatever `clampActive` and `variantHigh` do. Only power-on reset clears them.
- R8: After the fault sets, neither `onCount` nor the window position changes again until reset.
- R9: A change on `variantHigh` after reset has been released has no effect on the limit in use.
- R10: If on-time is split across windows so that no single window goes past the limit, no fault occurs, however large the sum over several windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| porRst | input | 1 | Power-on reset, synchronous, active high |
| clampActive | input | 1 | Clamp conducting level, asynchronous to clk |
| variantHigh | input | 1 | Limit choice, captured during reset: 0 low, 1 high |
| faultFlag | output | 1 | Latched overpower fault |
| shutdownReq | output | 1 | Latched shutdown request |
| onCount | output | ACC_W | On-ticks accumulated in the current window |

## Verification
An edge on `clampActive` reaches the accumulator after two clock edges through the synchronizer. It then counts only on the next prescaler tick, so it shows up on `onCount` between two and two-plus-DIV clock edges later. A fault appears on `faultFlag` and `shutdownReq` on the same edge as the increment that passes the limit. The bench holds a behavioural model that tracks every one of these register stages. It compares all three outputs on the falling edge of every clock, halfway between the update edges, and the model decides when the stimulus changes. This lets a boundary case, such as a window holding exactly the limit, be reached tick by tick without guessing the alignment.

// File: rtl/ontime_pkg.sv
package ontime_pkg;

  // Per-tick strobes from control to datapath
  typedef struct packed {
    logic winAdv;   // advance the window position
    logic accInc;   // add one on-tick
    logic accClr;   // restart the total for a new window
  } dpStrobe_t;

  typedef enum logic {WATCH = 1'b0, TRIPPED = 1'b1} guardState_t;

endpackage

// File: rtl/ontime_dp.sv
module ontime_dp
  import ontime_pkg::*;
#(
  parameter int DIV    = 5000,
  parameter int WINDOW = 10000,
  parameter int ACC_W  = 10
) (
  input  logic             clk,
  input  logic             porRst,
  input  logic             clampIn,
  input  dpStrobe_t        strobe,
  output logic             tick,
  output logic             clampSync,
  output logic             winLast,
  output logic [ACC_W-1:0] acc
);

  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int WIN_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;

  logic [1:0]       syncQ;
  logic [DIV_W-1:0] divCnt;
  logic [WIN_W-1:0] winCnt;

  // Two-stage synchronizer on the asynchronous clamp level
  always_ff @(posedge clk) begin
    if (porRst) syncQ <= 2'b00;
    else        syncQ <= {syncQ[0], clampIn};
  end
  assign clampSync = syncQ[1];

  // Prescaler producing the sampling tick
  assign tick = (divCnt == DIV_W'(DIV - 1));
  always_ff @(posedge clk) begin
    if (porRst)    divCnt <= '0;
    else if (tick) divCnt <= '0;
    else           divCnt <= divCnt + 1'b1;
  end

  // Window position in ticks
  assign winLast = (winCnt == WIN_W'(WINDOW - 1));
  always_ff @(posedge clk) begin
    if (porRst)             winCnt <= '0;
    else if (strobe.winAdv) winCnt <= winLast ? '0 : winCnt + 1'b1;
  end

  // On-time accumulator
  always_ff @(posedge clk) begin
    if (porRst)             acc <= '0;
    else if (strobe.accClr) acc <= '0;
    else if (strobe.accInc) acc <= acc + 1'b1;
  end

endmodule

// File: rtl/ontime_ctrl.sv
module ontime_ctrl
  import ontime_pkg::*;
#(
  parameter int LOW   = 512,
  parameter int HIGH  = 768,
  parameter int ACC_W = 10
) (
  input  logic             clk,
  input  logic             porRst,
  input  logic             variantHigh,
  input  logic             tick,
  input  logic             clampSync,
  input  logic             winLast,
  input  logic [ACC_W-1:0] acc,
  output dpStrobe_t        strobe,
  output logic             faultFlag,
  output logic             shutReq
);

  guardState_t      state;
  logic             selHigh;
  logic [ACC_W-1:0] limit;
  logic             live;
  logic             overLimit;
  logic             faultNow;

  // Limit choice is captured only while reset is held
  always_ff @(posedge clk) begin
    if (porRst) selHigh <= variantHigh;
  end

  assign limit     = selHigh ? ACC_W'(HIGH) : ACC_W'(LOW);
  assign live      = tick && (state == WATCH);
  assign overLimit = clampSync && (acc >= limit);
  assign faultNow  = live && overLimit;

  always_comb begin
    strobe.winAdv = live;
    strobe.accInc = live && clampSync;
    strobe.accClr = live && winLast && !overLimit;
  end

  always_ff @(posedge clk) begin
    if (porRst)        state <= WATCH;
    else if (faultNow) state <= TRIPPED;
  end
  assign faultFlag = (state == TRIPPED);

  // Shutdown request held in its own flop
  always_ff @(posedge clk) begin
    if (porRst)        shutReq <= 1'b0;
    else if (faultNow) shutReq <= 1'b1;
  end

endmodule

// File: rtl/ontime_guard.sv
module ontime_guard
  import ontime_pkg::*;
#(
  parameter int CLK_HZ       = 50_000_000,
  parameter int TICK_HZ      = 10_000,
  parameter int WINDOW_TICKS = 10_000,
  parameter int LOW_TICKS    = 512,
  parameter int HIGH_TICKS   = 768,
  localparam int MAX_TICKS   = (HIGH_TICKS > LOW_TICKS) ? HIGH_TICKS : LOW_TICKS,
  localparam int ACC_W       = $clog2(MAX_TICKS + 2)
) (
  input  logic             clk,
  input  logic             porRst,
  input  logic             clampActive,
  input  logic             variantHigh,
  output logic             faultFlag,
  output logic             shutdownReq,
  output logic [ACC_W-1:0] onCount
);

  localparam int DIV = (CLK_HZ / TICK_HZ > 0) ? CLK_HZ / TICK_HZ : 1;

  dpStrobe_t strobe;
  logic      tick;
  logic      clampSync;
  logic      winLast;

  ontime_dp #(.DIV(DIV), .WINDOW(WINDOW_TICKS), .ACC_W(ACC_W)) dp (
    .clk(clk), .porRst(porRst), .clampIn(clampActive), .strobe(strobe),
    .tick(tick), .clampSync(clampSync), .winLast(winLast), .acc(onCount)
  );

  ontime_ctrl #(.LOW(LOW_TICKS), .HIGH(HIGH_TICKS), .ACC_W(ACC_W)) ctrl (
    .clk(clk), .porRst(porRst), .variantHigh(variantHigh), .tick(tick),
    .clampSync(clampSync), .winLast(winLast), .acc(onCount),
    .strobe(strobe), .faultFlag(faultFlag), .shutReq(shutdownReq)
  );

endmodule

// File: rtl/ontime_guard_chk.sv
module ontime_guard_chk #(
  parameter int LOW   = 512,
  parameter int HIGH  = 768,
  parameter int ACC_W = 10
) (
  input logic             clk,
  input logic             porRst,
  input logic             faultFlag,
  input logic             shutdownReq,
  input logic [ACC_W-1:0] onCount
);

  localparam int CEIL = (HIGH > LOW) ? HIGH + 1 : LOW + 1;

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (porRst)
    faultFlag |=> faultFlag);  // R7

  AST_SHUTDOWN_MATCH: assert property (@(posedge clk) disable iff (porRst)
    shutdownReq == faultFlag);  // R7

  AST_FROZEN_COUNT: assert property (@(posedge clk) disable iff (porRst)
    faultFlag |=> $stable(onCount));  // R8

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (porRst)
    (onCount != $past(onCount)) |->
      (onCount == ACC_W'($past(onCount) + 1'b1) || onCount == '0));  // R2

  AST_TRIP_AT_LIMIT: assert property (@(posedge clk) disable iff (porRst)
    $rose(faultFlag) |-> (onCount == ACC_W'(LOW + 1) || onCount == ACC_W'(HIGH + 1)));  // R6

  AST_COUNT_CEILING: assert property (@(posedge clk) disable iff (porRst)
    onCount <= ACC_W'(CEIL));  // R4

endmodule

bind ontime_guard ontime_guard_chk #(
  .LOW(LOW_TICKS), .HIGH(HIGH_TICKS), .ACC_W(ACC_W)
) chk (
  .clk(clk), .porRst(porRst), .faultFlag(faultFlag),
  .shutdownReq(shutdownReq), .onCount(onCount)
);

// File: tb/tb_ontime_guard.sv
module tb_ontime_guard;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 30_000;
  localparam int TICK_HZ    = 10_000;
  localparam int DIV        = CLK_HZ / TICK_HZ;
  localparam int WIN        = 400;
  localparam int LOW        = 40;
  localparam int HIGH       = 60;
  localparam int ACC_W      = $clog2(HIGH + 2);
  localparam int WATCHDOG   = 150_000;

  logic clk = 1'b0;
  logic porRst = 1'b1;
  logic clampActive = 1'b0;
  logic variantHigh = 1'b0;
  logic faultFlag;
  logic shutdownReq;
  logic [ACC_W-1:0] onCount;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string phase = "R1";

  // Behavioural reference state
  int mS1 = 0, mS2 = 0, mDiv = 0, mWin = 0, mAcc = 0, mFlt = 0, mSel = 0;
  bit started = 1'b0;

  ontime_guard #(
    .CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .WINDOW_TICKS(WIN),
    .LOW_TICKS(LOW), .HIGH_TICKS(HIGH)
  ) dut (
    .clk(clk), .porRst(porRst), .clampActive(clampActive),
    .variantHigh(variantHigh), .faultFlag(faultFlag),
    .shutdownReq(shutdownReq), .onCount(onCount)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", phase, what, act, exp);
    end
  endtask

  // Reference model, advanced on each rising edge
  always @(posedge clk) begin
    int lim;
    bit tk;
    bit fNow;
    if (porRst) begin
      mS1 = 0; mS2 = 0; mDiv = 0; mWin = 0; mAcc = 0; mFlt = 0;
      mSel = variantHigh ? 1 : 0;
    end else begin
      tk = (mDiv == DIV - 1);
      mDiv = tk ? 0 : mDiv + 1;
      if (tk && mFlt == 0) begin
        lim = (mSel != 0) ? HIGH : LOW;
        fNow = (mS2 != 0) && (mAcc + 1 > lim);
        if (mS2 != 0) mAcc++;
        if (fNow) mFlt = 1;
        if (mWin == WIN - 1) begin
          mWin = 0;
          if (!fNow) mAcc = 0;
        end else begin
          mWin++;
        end
      end
      mS2 = mS1;
      mS1 = clampActive ? 1 : 0;
    end
    started = 1'b1;
  end

  // Compare every output away from the active edge
  always @(negedge clk) begin
    if (started) begin
      check(int'(onCount) == mAcc, "onCount", int'(onCount), mAcc);
      check(int'(faultFlag) == mFlt, "faultFlag", int'(faultFlag), mFlt);
      check(int'(shutdownReq) == mFlt, "shutdownReq", int'(shutdownReq), mFlt);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitWindowStart();
    do @(negedge clk); while (mWin != 0);
    do @(negedge clk); while (mWin == 0);
  endtask

  task automatic applyReset(input logic sel);
    porRst = 1'b1;
    variantHigh = sel;
    clampActive = 1'b0;
    cycles(5);
    porRst = 1'b0;
  endtask

  initial begin
    // R1: reset state
    phase = "R1";
    @(negedge clk);
    applyReset(1'b0);
    @(negedge clk);
    check(onCount == '0 && !faultFlag && !shutdownReq, "R1 reset outputs",
          int'(onCount) + int'(faultFlag) + int'(shutdownReq), 0);

    // R2: on-ticks accumulate one per tick while clamp is high
    phase = "R2";
    clampActive = 1'b1;
    cycles(60);
    clampActive = 1'b0;
    cycles(10);
    check(int'(onCount) >= 19 && int'(onCount) <= 21, "R2 count after 20 ticks",
          int'(onCount), 20);

    // R3: total restarts at the window boundary
    phase = "R3";
    do @(negedge clk); while (mWin != 0);
    cycles(2);
    check(onCount == '0, "R3 count after boundary", int'(onCount), 0);

    // R10: spread on-time below the limit in each window
    phase = "R10";
    waitWindowStart();
    clampActive = 1'b1;
    while (mAcc < 35) @(negedge clk);
    clampActive = 1'b0;
    waitWindowStart();
    clampActive = 1'b1;
    while (mAcc < 35) @(negedge clk);
    clampActive = 1'b0;
    cycles(10);
    check(!faultFlag, "R10 no fault across windows", int'(faultFlag), 0);

    // R4: exactly LOW on-ticks in one window is not a fault
    phase = "R4";
    waitWindowStart();
    clampActive = 1'b1;
    while (mAcc < LOW - 3) @(negedge clk);
    clampActive = 1'b0;
    cycles(6);
    while (mAcc < LOW) begin
      clampActive = 1'b1;
      @(negedge clk);
      clampActive = 1'b0;
      cycles(4);
    end
    check(int'(onCount) == LOW, "R4 count at limit", int'(onCount), LOW);
    do @(negedge clk); while (mWin != 0);
    cycles(2);
    check(!faultFlag, "R4 no fault at exact limit", int'(faultFlag), 0);

    // R6: fault mid-window on crossing the low limit
    phase = "R6";
    waitWindowStart();
    clampActive = 1'b1;
    while (!faultFlag && mFlt == 0) @(negedge clk);
    check(faultFlag == 1'b1, "R4 fault set on crossing", int'(faultFlag), 1);
    check(int'(onCount) == LOW + 1, "R6 count at trip", int'(onCount), LOW + 1);
    check(mWin < WIN - 1, "R6 trip before window end", mWin, WIN - 2);

    // R8: frozen after the fault
    phase = "R8";
    cycles(WIN * DIV + 50);
    check(int'(onCount) == LOW + 1, "R8 count frozen", int'(onCount), LOW + 1);

    // R7: inputs cannot clear the fault
    phase = "R7";
    for (int i = 0; i < 20; i++) begin
      clampActive = ~clampActive;
      variantHigh = ~variantHigh;
      cycles(7);
    end
    check(faultFlag && shutdownReq, "R7 fault held",
          int'(faultFlag) + int'(shutdownReq), 2);

    // R5 and R9: high variant captured at reset, later change ignored
    phase = "R5";
    applyReset(1'b1);
    variantHigh = 1'b0;
    @(negedge clk);
    check(!faultFlag && onCount == '0, "R1 cleared by reset", int'(faultFlag), 0);
    clampActive = 1'b1;
    while (mFlt == 0) @(negedge clk);
    check(int'(onCount) == HIGH + 1, "R5 trip at high limit", int'(onCount), HIGH + 1);
    phase = "R9";
    check(faultFlag && int'(onCount) != LOW + 1, "R9 select change ignored",
          int'(onCount), HIGH + 1);
    clampActive = 1'b0;
    cycles(20);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule